// File: doc/BRIEF.md
# Per-Timeslot Trunk Conditioning Unit

This block conditions the 24 byte-wide channels of a T1 framer datapath on their way to and from a serial backplane. Every channel has a small control entry. Two shared bytes supply the fill values. On the receive side, a byte arriving from the framer can be swapped for the receive fill byte, bit-inverted, or both, before it leaves on the backplane output. On the transmit side, bytes from the backplane are stored in a per-channel transmit memory. The framer reads that memory one channel at a time. A channel can be frozen, which stops backplane writes to its memory entry and sources the transmit fill byte instead. A channel can also be inverted on the way out.

Software programs the control table and the two fill bytes through a simple write port. Each datapath carries a channel index and a valid strobe. Both the receive output and the transmit read output are registered, so a result appears one clock after its request.

Top module: `tsc_unit`

## Requirements
- R1: A register write at address a with 0 ≤ a < 24 loads that channel's control entry from bits [3:0] of the data: bit 0 is receive substitute, bit 1 is receive invert, bit 2 is transmit invert, bit 3 is transmit freeze. Address 24 loads the receive fill byte. Address 25 loads the transmit fill byte.
- R2: A receive byte presented with `rx_in_valid` appears on `rx_out_data` one clock later, with `rx_out_valid` high and `rx_out_slot` equal to its channel. A clock with no receive strobe leaves `rx_out_valid` low one clock later.
- R3: When a channel's receive-substitute bit is set, its output byte is the receive fill byte instead of the received byte.
- R4: When a channel's receive-invert bit is set, its output byte is bitwise inverted. If substitute is also set, the fill byte is inverted.
- R5: A transmit read request for a channel returns, one clock later, `tx_out_valid` high, the channel on `tx_out_slot`, and the stored byte. The byte is bitwise inverted when that channel's transmit-invert bit is set.
- R6: A backplane write updates an unfrozen channel's transmit memory entry. While the channel is frozen, writes leave the entry unchanged, and the old value is read back once the freeze is cleared.
- R7: A transmit read of a frozen channel returns the transmit fill byte, inverted when transmit invert is also set.
- R8: A control write that lands in the same clock as a byte for that channel does not affect that byte. The next byte uses the new setting.
- R9: Reset clears every control entry, both fill bytes, the transmit memory and both output valid flags. Data then passes unmodified.
- R10: A channel index of 24 or above passes receive data unmodified. Backplane writes to such an index are dropped, and transmit reads of it return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (5) | Register address |
| reg_wdata | input | DW (8) | Register write data |
| rx_in_valid | input | 1 | Receive byte strobe from the framer |
| rx_in_slot | input | SLOT_W (5) | Channel of the receive byte |
| rx_in_data | input | DW (8) | Receive byte |
| rx_out_valid | output | 1 | Conditioned receive byte valid |
| rx_out_slot | output | SLOT_W (5) | Channel of the conditioned receive byte |
| rx_out_data | output | DW (8) | Conditioned receive byte to the backplane |
| bp_in_valid | input | 1 | Backplane transmit byte strobe |
| bp_in_slot | input | SLOT_W (5) | Channel of the backplane byte |
| bp_in_data | input | DW (8) | Backplane transmit byte |
| tx_rd_req | input | 1 | Transmit read request from the framer |
| tx_rd_slot | input | SLOT_W (5) | Channel to read |
| tx_out_valid | output | 1 | Transmit byte valid |
| tx_out_slot | output | SLOT_W (5) | Channel of the transmit byte |
| tx_out_data | output | DW (8) | Conditioned transmit byte |

## Verification
The bench goes after the control combinations where ordering matters. With substitute and invert set together, a design that applied them in the wrong order would output the fill byte uninverted. With freeze and invert set together, a design that dropped the invert would send the raw fill byte. It also checks the frozen-write window. A design that still wrote memory while frozen would return the blocked byte after the freeze is cleared instead of the byte stored earlier. A control write in the same clock as a byte for that channel is tested; a design that forwarded the new setting would alter that byte a cycle early. Out-of-range channel indices are tested as well; a design without a range guard would alias them onto real entries or read undefined memory.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   // Per-channel control entry; bit 0 is the lowest field (rx_sub).
   typedef struct packed {
      logic tx_frz;   // bit 3: hold transmit memory, send fill byte
      logic tx_inv;   // bit 2: invert transmit byte
      logic rx_inv;   // bit 1: invert receive byte
      logic rx_sub;   // bit 0: replace receive byte with fill byte
   } chan_ctl_t;

   localparam int CTL_W = $bits(chan_ctl_t);

endpackage

// File: rtl/tsc_ctrl_table.sv
module tsc_ctrl_table
   import tsc_pkg::*;
#(
   parameter int NUM_SLOTS = 24,
   parameter int DW        = 8,
   parameter int SLOT_W    = 5,
   parameter int REG_AW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic [SLOT_W-1:0] rx_lk_slot,
   input  logic [SLOT_W-1:0] wr_lk_slot,
   input  logic [SLOT_W-1:0] rd_lk_slot,
   output chan_ctl_t         rx_lk_ctl,
   output chan_ctl_t         wr_lk_ctl,
   output chan_ctl_t         rd_lk_ctl,
   output logic [DW-1:0]     rx_fill,
   output logic [DW-1:0]     tx_fill
);

   localparam logic [REG_AW-1:0] RX_FILL_ADDR = REG_AW'(NUM_SLOTS);
   localparam logic [REG_AW-1:0] TX_FILL_ADDR = REG_AW'(NUM_SLOTS + 1);
   localparam logic [SLOT_W-1:0] SLOT_LIMIT   = SLOT_W'(NUM_SLOTS);

   chan_ctl_t ent_arr [NUM_SLOTS];

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ent
      chan_ctl_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we && (addr == REG_AW'(i))) begin
            q <= chan_ctl_t'(wdata[CTL_W-1:0]);
         end
      end
      assign ent_arr[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_fill <= '0;
         tx_fill <= '0;
      end else if (we) begin
         if (addr == RX_FILL_ADDR) rx_fill <= wdata;
         if (addr == TX_FILL_ADDR) tx_fill <= wdata;
      end
   end

   // Lookups read the registered table, so a same-cycle write is not seen.
   always_comb begin
      rx_lk_ctl = '0;
      if (rx_lk_slot < SLOT_LIMIT) rx_lk_ctl = ent_arr[rx_lk_slot];
   end

   always_comb begin
      wr_lk_ctl = '0;
      if (wr_lk_slot < SLOT_LIMIT) wr_lk_ctl = ent_arr[wr_lk_slot];
   end

   always_comb begin
      rd_lk_ctl = '0;
      if (rd_lk_slot < SLOT_LIMIT) rd_lk_ctl = ent_arr[rd_lk_slot];
   end

endmodule

// File: rtl/tsc_rx_path.sv
module tsc_rx_path
   import tsc_pkg::*;
#(
   parameter int DW     = 8,
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SLOT_W-1:0] in_slot,
   input  logic [DW-1:0]     in_data,
   input  chan_ctl_t         ctl,
   input  logic [DW-1:0]     fill,
   output logic              out_valid,
   output logic [SLOT_W-1:0] out_slot,
   output logic [DW-1:0]     out_data
);

   logic [DW-1:0] sel_byte;
   logic [DW-1:0] cond_byte;

   // Substitute first, then invert the result.
   assign sel_byte  = ctl.rx_sub ? fill : in_data;
   assign cond_byte = sel_byte ^ {DW{ctl.rx_inv}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_slot  <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_slot <= in_slot;
            out_data <= cond_byte;
         end
      end
   end

endmodule

// File: rtl/tsc_tx_path.sv
module tsc_tx_path
   import tsc_pkg::*;
#(
   parameter int NUM_SLOTS = 24,
   parameter int DW        = 8,
   parameter int SLOT_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [DW-1:0]     wr_data,
   input  chan_ctl_t         wr_ctl,
   input  logic              rd_req,
   input  logic [SLOT_W-1:0] rd_slot,
   input  chan_ctl_t         rd_ctl,
   input  logic [DW-1:0]     fill,
   output logic              out_valid,
   output logic [SLOT_W-1:0] out_slot,
   output logic [DW-1:0]     out_data
);

   localparam logic [SLOT_W-1:0] SLOT_LIMIT = SLOT_W'(NUM_SLOTS);

   logic [DW-1:0] mem_arr [NUM_SLOTS];
   logic          wr_open;

   // A frozen channel's entry is not written; out-of-range slots match no cell.
   assign wr_open = wr_valid && !wr_ctl.tx_frz;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cell
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_open && (wr_slot == SLOT_W'(i))) begin
            q <= wr_data;
         end
      end
      assign mem_arr[i] = q;
   end

   logic [DW-1:0] mem_rd;
   logic [DW-1:0] src_byte;
   logic [DW-1:0] cond_byte;

   always_comb begin
      mem_rd = '0;
      if (rd_slot < SLOT_LIMIT) mem_rd = mem_arr[rd_slot];
   end

   assign src_byte  = rd_ctl.tx_frz ? fill : mem_rd;
   assign cond_byte = src_byte ^ {DW{rd_ctl.tx_inv}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_slot  <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= rd_req;
         if (rd_req) begin
            out_slot <= rd_slot;
            out_data <= cond_byte;
         end
      end
   end

endmodule

// File: rtl/tsc_unit.sv
module tsc_unit
   import tsc_pkg::*;
#(
   parameter  int NUM_SLOTS = 24,
   parameter  int DW        = 8,
   localparam int SLOT_W    = $clog2(NUM_SLOTS + 1),
   localparam int REG_AW    = $clog2(NUM_SLOTS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   input  logic              rx_in_valid,
   input  logic [SLOT_W-1:0] rx_in_slot,
   input  logic [DW-1:0]     rx_in_data,
   output logic              rx_out_valid,
   output logic [SLOT_W-1:0] rx_out_slot,
   output logic [DW-1:0]     rx_out_data,
   input  logic              bp_in_valid,
   input  logic [SLOT_W-1:0] bp_in_slot,
   input  logic [DW-1:0]     bp_in_data,
   input  logic              tx_rd_req,
   input  logic [SLOT_W-1:0] tx_rd_slot,
   output logic              tx_out_valid,
   output logic [SLOT_W-1:0] tx_out_slot,
   output logic [DW-1:0]     tx_out_data
);

   initial begin : chk_params
      assert (NUM_SLOTS >= 2)
         else $fatal(1, "tsc_unit: NUM_SLOTS must be at least 2");
      assert (DW >= CTL_W)
         else $fatal(1, "tsc_unit: DW too narrow for a control entry");
   end

   chan_ctl_t     rx_ctl;
   chan_ctl_t     wr_ctl;
   chan_ctl_t     rd_ctl;
   logic [DW-1:0] rx_fill;
   logic [DW-1:0] tx_fill;

   tsc_ctrl_table #(
      .NUM_SLOTS (NUM_SLOTS),
      .DW        (DW),
      .SLOT_W    (SLOT_W),
      .REG_AW    (REG_AW)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (reg_we),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .rx_lk_slot (rx_in_slot),
      .wr_lk_slot (bp_in_slot),
      .rd_lk_slot (tx_rd_slot),
      .rx_lk_ctl  (rx_ctl),
      .wr_lk_ctl  (wr_ctl),
      .rd_lk_ctl  (rd_ctl),
      .rx_fill    (rx_fill),
      .tx_fill    (tx_fill)
   );

   tsc_rx_path #(
      .DW     (DW),
      .SLOT_W (SLOT_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (rx_in_valid),
      .in_slot   (rx_in_slot),
      .in_data   (rx_in_data),
      .ctl       (rx_ctl),
      .fill      (rx_fill),
      .out_valid (rx_out_valid),
      .out_slot  (rx_out_slot),
      .out_data  (rx_out_data)
   );

   tsc_tx_path #(
      .NUM_SLOTS (NUM_SLOTS),
      .DW        (DW),
      .SLOT_W    (SLOT_W)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (bp_in_valid),
      .wr_slot   (bp_in_slot),
      .wr_data   (bp_in_data),
      .wr_ctl    (wr_ctl),
      .rd_req    (tx_rd_req),
      .rd_slot   (tx_rd_slot),
      .rd_ctl    (rd_ctl),
      .fill      (tx_fill),
      .out_valid (tx_out_valid),
      .out_slot  (tx_out_slot),
      .out_data  (tx_out_data)
   );

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
   parameter int NUM_SLOTS = 24,
   parameter int DW        = 8,
   parameter int SLOT_W    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic              rx_in_valid,
   input logic [SLOT_W-1:0] rx_in_slot,
   input logic [DW-1:0]     rx_in_data,
   input logic              rx_out_valid,
   input logic [SLOT_W-1:0] rx_out_slot,
   input logic [DW-1:0]     rx_out_data,
   input logic              tx_rd_req,
   input logic [SLOT_W-1:0] tx_rd_slot,
   input logic              tx_out_valid,
   input logic [SLOT_W-1:0] tx_out_slot,
   input logic [DW-1:0]     tx_out_data
);

   localparam logic [SLOT_W-1:0] SLOT_LIMIT = SLOT_W'(NUM_SLOTS);

   // Set once software has touched any register since reset.
   logic cfg_touched;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_touched <= 1'b0;
      else if (reg_we) cfg_touched <= 1'b1;
   end

   AST_RX_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_in_valid |=> rx_out_valid);                                   // R2
   AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_in_valid |=> !rx_out_valid);                                 // R2
   AST_RX_SLOT_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      rx_in_valid |=> (rx_out_slot == $past(rx_in_slot)));             // R2
   AST_TX_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rd_req |=> (tx_out_valid && tx_out_slot == $past(tx_rd_slot))); // R5
   AST_RX_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_in_valid && !cfg_touched) |=> (rx_out_data == $past(rx_in_data))); // R9
   AST_RX_OOR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_in_valid && rx_in_slot >= SLOT_LIMIT) |=> (rx_out_data == $past(rx_in_data))); // R10
   AST_TX_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rd_req && tx_rd_slot >= SLOT_LIMIT) |=> (tx_out_data == '0)); // R10

endmodule

bind tsc_unit tsc_checker #(
   .NUM_SLOTS (NUM_SLOTS),
   .DW        (DW),
   .SLOT_W    (SLOT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_we       (reg_we),
   .rx_in_valid  (rx_in_valid),
   .rx_in_slot   (rx_in_slot),
   .rx_in_data   (rx_in_data),
   .rx_out_valid (rx_out_valid),
   .rx_out_slot  (rx_out_slot),
   .rx_out_data  (rx_out_data),
   .tx_rd_req    (tx_rd_req),
   .tx_rd_slot   (tx_rd_slot),
   .tx_out_valid (tx_out_valid),
   .tx_out_slot  (tx_out_slot),
   .tx_out_data  (tx_out_data)
);

// File: tb/tb_tsc_unit.sv
`timescale 1ns/1ps
module tb_tsc_unit;

   localparam int NS = 24;
   localparam int DW = 8;
   localparam int SW = 5;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic          rx_in_valid = 1'b0;
   logic [SW-1:0] rx_in_slot = '0;
   logic [DW-1:0] rx_in_data = '0;
   logic          rx_out_valid;
   logic [SW-1:0] rx_out_slot;
   logic [DW-1:0] rx_out_data;
   logic          bp_in_valid = 1'b0;
   logic [SW-1:0] bp_in_slot = '0;
   logic [DW-1:0] bp_in_data = '0;
   logic          tx_rd_req = 1'b0;
   logic [SW-1:0] tx_rd_slot = '0;
   logic          tx_out_valid;
   logic [SW-1:0] tx_out_slot;
   logic [DW-1:0] tx_out_data;

   int checks   = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   tsc_unit #(.NUM_SLOTS(NS), .DW(DW)) dut (.*);

   // Control bits: [0] rx substitute, [1] rx invert, [2] tx invert, [3] tx freeze.
   // Fill bytes: rx 0x5A, tx 0xE1. Row i uses channel i.
   typedef struct packed {
      logic [3:0]    ctl;
      logic [DW-1:0] din;
      logic [DW-1:0] rx_exp;
      logic [DW-1:0] tx_exp;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{4'h0, 8'h3C, 8'h3C, 8'h3C},
      '{4'h1, 8'h3C, 8'h5A, 8'h3C},
      '{4'h2, 8'h3C, 8'hC3, 8'h3C},
      '{4'h3, 8'h3C, 8'hA5, 8'h3C},
      '{4'h4, 8'h12, 8'h12, 8'hED},
      '{4'h8, 8'h12, 8'h12, 8'hE1},
      '{4'hC, 8'h12, 8'h12, 8'h1E},
      '{4'hF, 8'h96, 8'hA5, 8'h1E},
      '{4'hA, 8'h0F, 8'hF0, 8'hE1}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rx_chk(input int s, input logic [DW-1:0] d,
                         input logic [DW-1:0] exp, input string req);
      @(negedge clk);
      rx_in_valid = 1'b1; rx_in_slot = SW'(s); rx_in_data = d;
      @(posedge clk); #1;
      rx_in_valid = 1'b0;
      check(rx_out_valid && rx_out_slot == SW'(s) && rx_out_data == exp, req,
            {rx_out_valid, 10'd0, rx_out_slot, 8'd0, rx_out_data},
            {1'b1, 10'd0, SW'(s), 8'd0, exp});
   endtask

   task automatic bp_wr(input int s, input logic [DW-1:0] d);
      @(negedge clk);
      bp_in_valid = 1'b1; bp_in_slot = SW'(s); bp_in_data = d;
      @(posedge clk); #1;
      bp_in_valid = 1'b0;
   endtask

   task automatic tx_chk(input int s, input logic [DW-1:0] exp, input string req);
      @(negedge clk);
      tx_rd_req = 1'b1; tx_rd_slot = SW'(s);
      @(posedge clk); #1;
      tx_rd_req = 1'b0;
      check(tx_out_valid && tx_out_slot == SW'(s) && tx_out_data == exp, req,
            {tx_out_valid, 10'd0, tx_out_slot, 8'd0, tx_out_data},
            {1'b1, 10'd0, SW'(s), 8'd0, exp});
   endtask

   initial begin : watchdog
      #500000;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // R9: reset state
      check(!rx_out_valid && !tx_out_valid, "R9 valids low", {rx_out_valid, tx_out_valid}, 0);
      @(negedge clk) rst_n = 1'b1;
      rx_chk(23, 8'hC7, 8'hC7, "R9 pass after reset");
      tx_chk(5, 8'h00, "R9 memory cleared");

      // Vector table: R1, R3, R4, R5, R7
      reg_wr(NS, 8'h5A);
      reg_wr(NS + 1, 8'hE1);
      for (int i = 0; i < NV; i++) begin
         reg_wr(i, {4'h0, VECS[i].ctl});
         rx_chk(i, VECS[i].din, VECS[i].rx_exp, "R1,R3,R4 rx vector");
         bp_wr(i, VECS[i].din);
         tx_chk(i, VECS[i].tx_exp, "R5,R6,R7 tx vector");
      end

      // R2: idle cycle drops valid
      @(negedge clk);
      @(posedge clk); #1;
      check(!rx_out_valid, "R2 idle", rx_out_valid, 0);

      // R6: freeze window keeps old memory content
      bp_wr(10, 8'h44);
      tx_chk(10, 8'h44, "R6 write unfrozen");
      reg_wr(10, 8'h08);
      bp_wr(10, 8'h99);
      tx_chk(10, 8'hE1, "R7 frozen read");
      reg_wr(10, 8'h00);
      tx_chk(10, 8'h44, "R6 blocked write");
      bp_wr(10, 8'h99);
      tx_chk(10, 8'h99, "R6 write after unfreeze");

      // R8: control write in the same clock as a receive byte
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(11); reg_wdata = 8'h02;
      rx_in_valid = 1'b1; rx_in_slot = SW'(11); rx_in_data = 8'h55;
      @(posedge clk); #1;
      reg_we = 1'b0; rx_in_valid = 1'b0;
      check(rx_out_data == 8'h55, "R8 old setting", rx_out_data, 8'h55);
      rx_chk(11, 8'h55, 8'hAA, "R8 new setting");

      // R8: freeze set in the same clock as a transmit read
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(12); reg_wdata = 8'h08;
      tx_rd_req = 1'b1; tx_rd_slot = SW'(12);
      @(posedge clk); #1;
      reg_we = 1'b0; tx_rd_req = 1'b0;
      check(tx_out_data == 8'h00, "R8 tx old setting", tx_out_data, 8'h00);
      tx_chk(12, 8'hE1, "R8 tx new setting");

      // R1: receive fill byte reload, seen on channel 1 (substitute)
      reg_wr(NS, 8'h00);
      rx_chk(1, 8'h3C, 8'h00, "R1,R3 fill reload");

      // R10: out-of-range channel
      rx_chk(30, 8'h6B, 8'h6B, "R10 rx pass");
      bp_wr(30, 8'h77);
      tx_chk(30, 8'h00, "R10 tx read zero");

      // R9: reset mid-run clears control and memory
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      rx_chk(3, 8'h3C, 8'h3C, "R9 control cleared");
      tx_chk(10, 8'h00, "R9 memory cleared");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule